// File: doc/BRIEF.md
# Bus Request Throttle with Starvation Override

This block gates the request path of a DMA engine onto a shared bus. Each request arrives as a valid/ready handshake. `req_valid` says that a request is pending, and `req_is_read` gives its direction. The block raises `req_ready` only when the request may go out. A request is issued in any cycle where `req_valid` and `req_ready` are both high.

When throttling is on for the request's direction, the block watches a blocking signal from the target agent. It holds the request back until that signal has been low for a full window of consecutive cycles. Each time the blocker returns too early while a request waits, the block counts a backoff. Once enough backoffs have piled up, the block lets the request out on the very next cycle the blocker is low.

Independently of throttling, the block limits the number of reads in flight. Each read issue takes a credit, and each read return pulse gives one back.

Back-pressure rules are as follows. `req_ready` depends only on the direction, the throttle selects, the blocker and internal state, never on `req_valid`. The source holds `req_valid` and `req_is_read` until the handshake completes. A cycle with `req_ready` low moves no request.

Top module: `bus_req_throttle`

## Requirements
- R1: Throttling is chosen per direction: `throttle_rd` applies when `req_is_read`=1, and `throttle_wr` applies when `req_is_read`=0.
- R2: For a throttled request, unless R4 applies, `req_ready` is high only if `bus_blocked` was low in each of the previous 4 cycles. The level of `bus_blocked` in the current cycle does not matter.
- R3: A backoff is counted in a cycle where a throttled request is pending and not ready, `bus_blocked` is high, and the run of clear cycles is between 1 and 3.
- R4: After 16 backoffs, a throttled request becomes ready in any cycle where `bus_blocked` is low, even with a shorter clear run. It stays not ready while `bus_blocked` is high.
- R5: With throttling off for the request's direction, `req_ready` is high whenever R6 does not block it, whatever the state of `bus_blocked`.
- R6: `req_ready` is low for reads while 4 reads are outstanding. Writes are never limited by outstanding reads.
- R7: An issued request clears both the clear-run count and the backoff count. The next throttled request therefore needs a fresh 4-cycle window.
- R8: The outstanding-read count rises on a read issue and falls on a `rd_return` pulse. If both happen in the same cycle, the count is unchanged. A return when the count is zero is ignored.
- R9: `req_ready` does not depend on `req_valid`. Once the window is complete, ready stays high with no request pending.
- R10: After reset, the clear-run count, the backoff count and the outstanding-read count are zero. A throttled request is therefore not ready, and an unthrottled read is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is pending |
| req_is_read | input | 1 | 1 = read request, 0 = write request |
| req_ready | output | 1 | The request may be issued this cycle |
| bus_blocked | input | 1 | Blocking indication from the target agent |
| throttle_rd | input | 1 | Throttle reads for the current transfer |
| throttle_wr | input | 1 | Throttle writes for the current transfer |
| rd_return | input | 1 | Pulse: data for one outstanding read has returned |

## Verification
The bench runs the blocker in short clear bursts and tallies the backoffs. It checks that 15 backoffs still hold the request back, and that the 16th releases it on the next clear cycle but not while the blocker is high. A design with an off-by-one in either count would release one burst early or late.

The bench also fills the read credits and then sends a write. It returns a credit in a blocked cycle, and overlaps a return with a new issue. Credit arithmetic that is wrong would leak or invent a slot, and a limit that wrongly covers writes would stall the write.

After a window completes, the bench holds the request back and confirms that ready stays high and that a late blocker pulse does not matter. A design that counted the current cycle, or forgot to clear on issue, would fail there.

// File: rtl/bus_thr_pkg.sv
package bus_thr_pkg;
  localparam int unsigned DEF_CLEAR_WIN     = 4;
  localparam int unsigned DEF_BACKOFF_LIMIT = 16;
  localparam int unsigned DEF_MAX_READS     = 4;

  typedef enum logic {
    DIR_WR = 1'b0,
    DIR_RD = 1'b1
  } req_dir_e;
endpackage

// File: rtl/clear_window.sv
module clear_window #(
  parameter int unsigned WIN = 4,
  localparam int unsigned CW = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blocked,
  input  logic          issue,
  output logic [CW-1:0] run_cnt,
  output logic          win_ok
);
  // run_cnt counts consecutive earlier cycles with the blocker low, saturating at WIN.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (issue || blocked) begin
      run_cnt <= '0;
    end else if (run_cnt != CW'(WIN)) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign win_ok = (run_cnt == CW'(WIN));
endmodule

// File: rtl/backoff_ctr.sv
module backoff_ctr #(
  parameter int unsigned LIMIT = 16,
  localparam int unsigned BW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          backoff_evt,
  input  logic          issue,
  output logic [BW-1:0] bo_cnt,
  output logic          starved
);
  assign starved = (bo_cnt == BW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bo_cnt <= '0;
    end else if (issue) begin
      bo_cnt <= '0;
    end else if (backoff_evt && !starved) begin
      bo_cnt <= bo_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/read_credit.sv
module read_credit #(
  parameter int unsigned MAX_READS = 4,
  localparam int unsigned OW = $clog2(MAX_READS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_issue,
  input  logic          rd_return,
  output logic [OW-1:0] out_cnt,
  output logic          full
);
  logic take, give;

  assign take = rd_issue;
  assign give = rd_return && (out_cnt != '0);
  assign full = (out_cnt == OW'(MAX_READS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_cnt <= '0;
    end else begin
      unique case ({take, give})
        2'b10:   out_cnt <= out_cnt + 1'b1;
        2'b01:   out_cnt <= out_cnt - 1'b1;
        default: out_cnt <= out_cnt;
      endcase
    end
  end
endmodule

// File: rtl/bus_req_throttle.sv
module bus_req_throttle
  import bus_thr_pkg::*;
#(
  parameter int unsigned CLEAR_WIN     = DEF_CLEAR_WIN,
  parameter int unsigned BACKOFF_LIMIT = DEF_BACKOFF_LIMIT,
  parameter int unsigned MAX_READS     = DEF_MAX_READS,
  localparam int unsigned CW = $clog2(CLEAR_WIN + 1),
  localparam int unsigned BW = $clog2(BACKOFF_LIMIT + 1),
  localparam int unsigned OW = $clog2(MAX_READS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_is_read,
  output logic req_ready,
  input  logic bus_blocked,
  input  logic throttle_rd,
  input  logic throttle_wr,
  input  logic rd_return
);
  req_dir_e      dir;
  logic          thr_active;
  logic          issue, issue_rd;
  logic [CW-1:0] clr_run;
  logic          win_ok;
  logic [BW-1:0] bo_cnt;
  logic          starved;
  logic [OW-1:0] rd_out_cnt;
  logic          rd_full;
  logic          gate_ok, room_ok, waiting, backoff_evt;

  assign dir        = req_dir_e'(req_is_read);
  assign thr_active = (dir == DIR_RD) ? throttle_rd : throttle_wr;

  // Throttle gate: full clear window, or the starvation override on a clear cycle.
  assign gate_ok   = !thr_active || win_ok || (starved && !bus_blocked);
  // Read credits only limit reads.
  assign room_ok   = (dir == DIR_WR) || !rd_full;
  assign req_ready = gate_ok && room_ok;

  assign issue    = req_valid && req_ready;
  assign issue_rd = issue && (dir == DIR_RD);

  assign waiting     = req_valid && thr_active && !req_ready;
  assign backoff_evt = waiting && bus_blocked && (clr_run != '0) && !win_ok;

  clear_window #(.WIN(CLEAR_WIN)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .blocked (bus_blocked),
    .issue   (issue),
    .run_cnt (clr_run),
    .win_ok  (win_ok)
  );

  backoff_ctr #(.LIMIT(BACKOFF_LIMIT)) u_bo (
    .clk         (clk),
    .rst_n       (rst_n),
    .backoff_evt (backoff_evt),
    .issue       (issue),
    .bo_cnt      (bo_cnt),
    .starved     (starved)
  );

  read_credit #(.MAX_READS(MAX_READS)) u_cred (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_issue  (issue_rd),
    .rd_return (rd_return),
    .out_cnt   (rd_out_cnt),
    .full      (rd_full)
  );
endmodule

// File: rtl/bus_req_throttle_chk.sv
module bus_req_throttle_chk #(
  parameter int unsigned CLEAR_WIN     = 4,
  parameter int unsigned BACKOFF_LIMIT = 16,
  parameter int unsigned MAX_READS     = 4,
  localparam int unsigned CW = $clog2(CLEAR_WIN + 1),
  localparam int unsigned BW = $clog2(BACKOFF_LIMIT + 1),
  localparam int unsigned OW = $clog2(MAX_READS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_is_read,
  input logic          req_ready,
  input logic          bus_blocked,
  input logic          throttle_rd,
  input logic          throttle_wr,
  input logic          rd_return,
  input logic [CW-1:0] clr_run,
  input logic [BW-1:0] bo_cnt,
  input logic [OW-1:0] out_cnt
);
  logic          active, hs, hs_rd;
  logic [CW-1:0] low_run;

  assign active = req_is_read ? throttle_rd : throttle_wr;
  assign hs     = req_valid && req_ready;
  assign hs_rd  = hs && req_is_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     low_run <= '0;
    else if (hs || bus_blocked)     low_run <= '0;
    else if (low_run != CW'(CLEAR_WIN)) low_run <= low_run + 1'b1;
  end

  // R6
  rd_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_rd |-> (out_cnt < OW'(MAX_READS)));

  // R8
  rd_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_rd && !rd_return) |=> (out_cnt == OW'($past(out_cnt) + 1'b1)));

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_rd && rd_return) |=> $stable(out_cnt));

  // R7
  issue_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> (clr_run == '0 && bo_cnt == '0));

  // R2
  window_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && active) |->
      ((low_run == CW'(CLEAR_WIN)) || (bo_cnt == BW'(BACKOFF_LIMIT) && !bus_blocked)));

  // R5
  unthrottled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && (!req_is_read || out_cnt < OW'(MAX_READS))) |-> req_ready);
endmodule

bind bus_req_throttle bus_req_throttle_chk #(
  .CLEAR_WIN     (CLEAR_WIN),
  .BACKOFF_LIMIT (BACKOFF_LIMIT),
  .MAX_READS     (MAX_READS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_is_read (req_is_read),
  .req_ready   (req_ready),
  .bus_blocked (bus_blocked),
  .throttle_rd (throttle_rd),
  .throttle_wr (throttle_wr),
  .rd_return   (rd_return),
  .clr_run     (clr_run),
  .bo_cnt      (bo_cnt),
  .out_cnt     (rd_out_cnt)
);

// File: tb/tb_bus_req_throttle.sv
module tb_bus_req_throttle;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_is_read = 1'b0, bus_blocked = 1'b1;
  logic throttle_rd = 1'b0, throttle_wr = 1'b0, rd_return = 1'b0;
  logic req_ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit    exp;
    string tag;
  } exp_item_t;

  exp_item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_req_throttle dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_is_read (req_is_read),
    .req_ready   (req_ready),
    .bus_blocked (bus_blocked),
    .throttle_rd (throttle_rd),
    .throttle_wr (throttle_wr),
    .rd_return   (rd_return)
  );

  // Monitor: compares the ready output just after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        exp_item_t it;
        it = sb.pop_front();
        checks++;
        if (req_ready !== it.exp) begin
          errors++;
          $display("FAIL %s: req_ready=%0b expected=%0b", it.tag, req_ready, it.exp);
        end
      end
    end
  end

  // Driver: applies one cycle of stimulus and queues the expected ready.
  task automatic step(input bit v, input bit rd, input bit blk, input bit tr,
                      input bit tw, input bit ret, input bit chk, input bit exp,
                      input string tag);
    @(negedge clk);
    req_valid   = v;
    req_is_read = rd;
    bus_blocked = blk;
    throttle_rd = tr;
    throttle_wr = tw;
    rd_return   = ret;
    if (chk) begin
      exp_item_t it;
      it.exp = exp;
      it.tag = tag;
      sb.push_back(it);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0; req_is_read = 1'b0; bus_blocked = 1'b1;
    throttle_rd = 1'b0; throttle_wr = 1'b0; rd_return = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    // R10 reset state
    do_reset();
    step(0, 0, 0, 0, 1, 0, 1, 0, "R10 throttled write after reset");
    step(0, 1, 1, 0, 0, 0, 1, 1, "R10 unthrottled read after reset");

    // R2 / R7 window then issue
    do_reset();
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 1, 0, 1, 0, "R2 window not yet full");
    step(1, 0, 0, 0, 1, 0, 1, 1, "R2 window full");
    step(1, 0, 0, 0, 1, 0, 1, 0, "R7 issue restarts window");

    // R9 / R2 ready without valid, current blocker ignored
    do_reset();
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 0, 1, 0, "R9 filling window");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, 1, 1, "R9 ready held without valid");
    step(0, 0, 1, 0, 1, 0, 1, 1, "R2 current blocker ignored");
    step(0, 0, 0, 0, 1, 0, 1, 0, "R2 window broken by blocker");

    // R3 / R4 backoffs and override
    do_reset();
    for (int r = 0; r < 16; r++) begin
      step(1, 0, 0, 0, 1, 0, 1, 0, "R3 backoff round clear 1");
      step(1, 0, 0, 0, 1, 0, 1, 0, "R3 backoff round clear 2");
      step(1, 0, 1, 0, 1, 0, 1, 0, "R3 backoff round blocked");
    end
    step(1, 0, 1, 0, 1, 0, 1, 0, "R4 starved but blocked");
    step(1, 0, 0, 0, 1, 0, 1, 1, "R4 starved and clear");
    step(1, 0, 0, 0, 1, 0, 1, 0, "R7 backoff count cleared");

    // R5 unthrottled ignores blocker
    do_reset();
    step(1, 0, 1, 0, 0, 0, 1, 1, "R5 unthrottled write with blocker");

    // R6 / R8 read credits
    do_reset();
    step(0, 1, 1, 0, 0, 1, 1, 1, "R8 return at zero ignored");
    for (int i = 0; i < 4; i++) step(1, 1, 1, 0, 0, 0, 1, 1, "R6 read issue under limit");
    step(1, 1, 1, 0, 0, 0, 1, 0, "R6 read limit reached");
    step(1, 0, 1, 0, 0, 0, 1, 1, "R6 write not limited");
    step(1, 1, 1, 0, 0, 1, 1, 0, "R8 return while full");
    step(1, 1, 1, 0, 0, 1, 1, 1, "R8 issue with return");
    step(1, 1, 1, 0, 0, 0, 1, 1, "R8 issue after overlap");
    step(1, 1, 1, 0, 0, 0, 1, 0, "R8 full again");

    // R1 per-direction select
    do_reset();
    step(0, 1, 0, 1, 0, 0, 1, 0, "R1 read throttled");
    step(0, 0, 0, 1, 0, 0, 1, 1, "R1 write not throttled");
    step(0, 1, 0, 0, 1, 0, 1, 1, "R1 read not throttled");
    step(0, 0, 0, 0, 1, 0, 1, 0, "R1 write throttled");

    step(0, 0, 1, 0, 0, 0, 0, 0, "idle");
    @(negedge clk);
    #2;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule